// File: doc/BRIEF.md
# SD Card Read Clock Throttle

This block decides, cycle by cycle, whether the card clock may run while a host controller reads data blocks from an SD or MMC card. It keeps the receive FIFO from overflowing. Before each block it checks that enough free FIFO space is available. During a block it stops the clock only at points where stopping is safe. A divider outside the block supplies one tick per card bit period. The block passes that tick on as a sample strobe only while it lets the clock run. It counts samples to find block boundaries.

Software programs four settings before it issues a read command: a threshold-enable bit, a threshold in bytes, the block size in bytes and a stall limit. All four are copied into shadow registers on the command strobe and stay frozen until the transfer-done input. Writes made while a transfer is running are dropped.

Two modes exist. If the threshold is enabled and is at least the block size, a block begins only when the whole threshold fits in the FIFO, and the clock then runs through the block without a stop. Otherwise the clock is also stopped in the middle of a block whenever the FIFO is full. A stall counter raises a status output when the clock stays stopped with no FIFO drain for too long. Without it, such a hang would go unnoticed.

Top module: `sdReadThrottle`

## Requirements
- R1: While reset is asserted and directly after it, `cardClkEn`, `sampleStrobe`, `blockDone` and `stalled` are all 0.
- R2: With the threshold enabled (register 0 bit 0 = 1), the first sample of every block occurs only when the free FIFO space, (`fifoDepth` - `fifoLevel`) x 4 bytes, is at least the threshold. After the last sample of a block, `cardClkEn` is 0 for at least one cycle.
- R3: With the threshold enabled and set to at least the block size, `cardClkEn` is 1 in every cycle from the first sample of a block to its last sample.
- R4: When the threshold is enabled but below the block size, or when it is disabled, `cardClkEn` is 0 in every cycle where `fifoLevel` >= `fifoDepth`. The FIFO never receives a word while it is full.
- R5: With the threshold disabled, a block may start once at least one FIFO word is free. Inside a block, `cardClkEn` equals (`fifoLevel` < `fifoDepth`).
- R6: `sampleStrobe` is `cardClkEn` AND `bitTick`. With four data lanes, a block holds block size x 2 samples. `blockDone` is 1 exactly on the sample that completes a block.
- R7: Configuration writes use address 0 (bit 0 = threshold enable), 1 (threshold in bytes), 2 (block size in bytes) and 3 (stall limit in cycles). A write while a transfer is active has no effect on that transfer or on later ones.
- R8: Configuration is captured on `cmdIssue` while idle, and the clock stays off in the following cycle. A `cmdIssue` during a transfer is ignored and does not restart block counting.
- R9: With a nonzero stall limit L, `stalled` becomes 1 once the clock has been off for L cycles of an active transfer with no drop in `fifoLevel`. It returns to 0 after a drain or a clock restart. A limit of 0 disables it.
- R10: After `xferDone`, the block is idle and `cardClkEn` stays 0 until the next `cmdIssue`.
- R11: After reset, the block size is 512 bytes, so the first block takes 1024 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register address |
| cfgWrData | input | CFG_W | Configuration write data |
| cmdIssue | input | 1 | Read command issued; starts a transfer |
| xferDone | input | 1 | Transfer finished |
| fifoLevel | input | LVL_W | Receive FIFO fill level in words |
| fifoDepth | input | LVL_W | Receive FIFO depth in words |
| bitTick | input | 1 | One pulse per card bit period from the divider |
| cardClkEn | output | 1 | Card clock enable |
| sampleStrobe | output | 1 | A data sample is taken this cycle |
| blockDone | output | 1 | This sample completes a block |
| stalled | output | 1 | Clock has been held off too long with no drain |

## Verification
The bench goes after block boundaries that fall in the same cycle as the last FIFO word push. A design that compared space before that push registered would start the next block one word short and overflow. It runs random drain and tick rates with the threshold at or above the block size. A design that also gated on a full FIFO in this mode would drop the clock in mid-block. It writes a smaller threshold and reissues the command mid-transfer, then starts a new transfer on a part-full FIFO. A design that did not protect its registers would start the clock, and one that restarted on the second command would report the block end late. Finally it lets the FIFO sit with no drain and checks that the stall flag rises only after the programmed limit, then clears once the FIFO drains.

// File: rtl/sdThrottlePkg.sv
package sdThrottlePkg;

  typedef enum logic [1:0] {
    TH_IDLE = 2'd0,
    TH_WAIT = 2'd1,
    TH_RUN  = 2'd2
  } thrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic active;
    logic countSample;
    logic clearCount;
    logic clkEn;
  } thrCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic spaceOk;
    logic midStopOk;
    logic fifoFull;
    logic lastSample;
  } thrStat_t;

endpackage

// File: rtl/sdThrottleDp.sv
module sdThrottleDp
  import sdThrottlePkg::*;
#(
  parameter int CFG_W      = 16,
  parameter int LVL_W      = 10,
  parameter int WORD_BYTES = 4,
  parameter int DATA_LANES = 4,
  parameter int BLK_RESET  = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [LVL_W-1:0] fifoDepth,
  input  thrCtl_t          ctl,
  output thrStat_t         stat,
  output logic             stalled
);

  localparam int BYTE_SH = $clog2(WORD_BYTES);
  localparam int LANE_SH = $clog2(DATA_LANES);
  localparam int CNT_W   = CFG_W + 3;
  localparam int FREE_W  = LVL_W + BYTE_SH;
  localparam int CMP_W   = (FREE_W > CFG_W) ? FREE_W : CFG_W;

  // software-visible settings
  logic             cfgThrEn;
  logic [CFG_W-1:0] cfgThr;
  logic [CFG_W-1:0] cfgBlk;
  logic [CFG_W-1:0] cfgLimit;

  // per-transfer shadow copies
  logic             shThrEn;
  logic [CFG_W-1:0] shThr;
  logic [CFG_W-1:0] shBlk;
  logic [CFG_W-1:0] shLimit;

  logic [LVL_W-1:0] freeWords;
  logic [CMP_W-1:0] freeBytes;
  logic [CMP_W-1:0] thrCmp;
  logic [CNT_W-1:0] samplesPerBlk;
  logic [CNT_W-1:0] sampleCnt;
  logic [LVL_W-1:0] prevLevel;
  logic [CFG_W-1:0] stallCnt;
  logic             drainSeen;
  logic             fullNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgThrEn <= 1'b0;
      cfgThr   <= '0;
      cfgBlk   <= CFG_W'(BLK_RESET);
      cfgLimit <= '0;
    end else if (cfgWrEn && !ctl.active) begin
      unique case (cfgAddr)
        2'd0:    cfgThrEn <= cfgWrData[0];
        2'd1:    cfgThr   <= cfgWrData;
        2'd2:    cfgBlk   <= cfgWrData;
        default: cfgLimit <= cfgWrData;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shThrEn <= 1'b0;
      shThr   <= '0;
      shBlk   <= CFG_W'(BLK_RESET);
      shLimit <= '0;
    end else if (ctl.latchCfg) begin
      shThrEn <= cfgThrEn;
      shThr   <= cfgThr;
      shBlk   <= cfgBlk;
      shLimit <= cfgLimit;
    end
  end

  // free space in bytes
  always_comb begin
    fullNow   = (fifoLevel >= fifoDepth);
    freeWords = fullNow ? '0 : (fifoDepth - fifoLevel);
    freeBytes = CMP_W'(freeWords) << BYTE_SH;
    thrCmp    = CMP_W'(shThr);
  end

  assign samplesPerBlk = (CNT_W'(shBlk) << 3) >> LANE_SH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
    end else if (ctl.latchCfg || ctl.clearCount) begin
      sampleCnt <= '0;
    end else if (ctl.countSample) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  always_comb begin
    stat.fifoFull   = fullNow;
    stat.midStopOk  = !(shThrEn && (shThr >= shBlk));
    stat.lastSample = (sampleCnt == samplesPerBlk - 1'b1);
    if (shThrEn) begin
      stat.spaceOk = (freeBytes >= thrCmp);
    end else begin
      stat.spaceOk = (freeWords != '0);
    end
  end

  // stall watch: clock off, transfer active, FIFO not draining
  assign drainSeen = (fifoLevel < prevLevel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= '0;
      stallCnt  <= '0;
    end else begin
      prevLevel <= fifoLevel;
      if (!ctl.active || ctl.clkEn || drainSeen) begin
        stallCnt <= '0;
      end else if (stallCnt != {CFG_W{1'b1}}) begin
        stallCnt <= stallCnt + 1'b1;
      end
    end
  end

  assign stalled = ctl.active && !ctl.clkEn && (shLimit != '0) &&
                   (stallCnt >= shLimit);

endmodule

// File: rtl/sdThrottleCtl.sv
module sdThrottleCtl
  import sdThrottlePkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdIssue,
  input  logic     xferDone,
  input  logic     bitTick,
  input  thrStat_t stat,
  output thrCtl_t  ctl,
  output logic     cardClkEn,
  output logic     sampleStrobe,
  output logic     blockDone
);

  thrState_e state;
  thrState_e stateNext;
  logic      gateFull;

  assign gateFull     = stat.midStopOk && stat.fifoFull;
  assign cardClkEn    = (state == TH_RUN) && !gateFull;
  assign sampleStrobe = cardClkEn && bitTick;
  assign blockDone    = sampleStrobe && stat.lastSample;

  always_comb begin
    stateNext = state;
    unique case (state)
      TH_IDLE: if (cmdIssue) stateNext = TH_WAIT;
      TH_WAIT: begin
        if (xferDone)          stateNext = TH_IDLE;
        else if (stat.spaceOk) stateNext = TH_RUN;
      end
      TH_RUN: begin
        if (xferDone)       stateNext = TH_IDLE;
        else if (blockDone) stateNext = TH_WAIT;
      end
      default: stateNext = TH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= TH_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.latchCfg    = (state == TH_IDLE) && cmdIssue;
    ctl.active      = (state != TH_IDLE);
    ctl.countSample = sampleStrobe;
    ctl.clearCount  = blockDone;
    ctl.clkEn       = cardClkEn;
  end

endmodule

// File: rtl/sdReadThrottle.sv
module sdReadThrottle
  import sdThrottlePkg::*;
#(
  parameter int CFG_W      = 16,
  parameter int LVL_W      = 10,
  parameter int WORD_BYTES = 4,
  parameter int DATA_LANES = 4,
  parameter int BLK_RESET  = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             cmdIssue,
  input  logic             xferDone,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [LVL_W-1:0] fifoDepth,
  input  logic             bitTick,
  output logic             cardClkEn,
  output logic             sampleStrobe,
  output logic             blockDone,
  output logic             stalled
);

  thrCtl_t  ctl;
  thrStat_t stat;
  logic     xferActive;
  logic     midStopOk;

  assign xferActive = ctl.active;
  assign midStopOk  = stat.midStopOk;

  sdThrottleDp #(
    .CFG_W(CFG_W), .LVL_W(LVL_W), .WORD_BYTES(WORD_BYTES),
    .DATA_LANES(DATA_LANES), .BLK_RESET(BLK_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .fifoLevel(fifoLevel), .fifoDepth(fifoDepth),
    .ctl(ctl), .stat(stat), .stalled(stalled)
  );

  sdThrottleCtl u_ctl (
    .clk(clk), .rstN(rstN), .cmdIssue(cmdIssue), .xferDone(xferDone),
    .bitTick(bitTick), .stat(stat), .ctl(ctl), .cardClkEn(cardClkEn),
    .sampleStrobe(sampleStrobe), .blockDone(blockDone)
  );

endmodule

// File: rtl/sdReadThrottle_chk.sv
module sdReadThrottle_chk #(
  parameter int LVL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdIssue,
  input logic             xferDone,
  input logic [LVL_W-1:0] fifoLevel,
  input logic [LVL_W-1:0] fifoDepth,
  input logic             bitTick,
  input logic             cardClkEn,
  input logic             sampleStrobe,
  input logic             blockDone,
  input logic             xferActive,
  input logic             midStopOk
);

  a_r2_gap_after_block: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !cardClkEn);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel >= fifoDepth && midStopOk) |-> !sampleStrobe);

  a_r6_done_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> (bitTick && cardClkEn));

  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && $past(xferActive)) |-> $stable(midStopOk));

  a_r8_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIssue && !xferActive) |=> (xferActive && !cardClkEn));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !cmdIssue) |=> (!xferActive && !cardClkEn));

endmodule

bind sdReadThrottle sdReadThrottle_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdIssue(cmdIssue), .xferDone(xferDone),
  .fifoLevel(fifoLevel), .fifoDepth(fifoDepth), .bitTick(bitTick),
  .cardClkEn(cardClkEn), .sampleStrobe(sampleStrobe), .blockDone(blockDone),
  .xferActive(xferActive), .midStopOk(midStopOk)
);

// File: tb/sdReadThrottle_tb.sv
module sdReadThrottle_tb;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic        cmdIssue = 1'b0;
  logic        xferDone = 1'b0;
  logic [9:0]  fifoLevel = '0;
  logic [9:0]  fifoDepth = 10'(DEPTH);
  logic        bitTick = 1'b0;
  logic        cardClkEn, sampleStrobe, blockDone, stalled;

  always #4 clk = ~clk;

  sdReadThrottle u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cmdIssue(cmdIssue), .xferDone(xferDone),
    .fifoLevel(fifoLevel), .fifoDepth(fifoDepth), .bitTick(bitTick),
    .cardClkEn(cardClkEn), .sampleStrobe(sampleStrobe),
    .blockDone(blockDone), .stalled(stalled)
  );

  int checks = 0;
  int errors = 0;

  // bench FIFO and mode state
  int level = 0;
  int pendPush = 0, pendDrain = 0;
  int drainPct = 50, tickPct = 100;
  bit pendCmd = 0, pendDone = 0, pendWr = 0;
  int pendAddr = 0, pendData = 0;
  bit inXfer = 0;
  bit mThrEn = 0;
  int mThr = 0, mBlk = 512, spb = 1024;
  int blkCnt = 0, blocks = 0, byteSmp = 0, totSmp = 0, firstDoneAt = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int freeBytesOf(input int lvl);
    return (lvl >= DEPTH) ? 0 : (DEPTH - lvl) * 4;
  endfunction

  function automatic bit midStopAllowed(input bit en, input int thr, input int blk);
    return !(en && thr >= blk);
  endfunction

  task automatic cycle();
    @(negedge clk);
    level = level + pendPush - pendDrain;
    pendPush = 0;
    pendDrain = 0;
    fifoLevel = 10'(level);
    bitTick = ($urandom_range(99) < tickPct);
    cmdIssue = pendCmd;
    xferDone = pendDone;
    cfgWrEn = pendWr;
    cfgAddr = 2'(pendAddr);
    cfgWrData = 16'(pendData);
    pendCmd = 0;
    pendDone = 0;
    pendWr = 0;
    #1;
    if (inXfer) begin
      // R6: strobe and block end
      if (sampleStrobe != (cardClkEn && bitTick))
        chk(0, "R6 strobe", sampleStrobe, cardClkEn && bitTick);
      chk(blockDone == (sampleStrobe && blkCnt == spb - 1), "R6 blockDone",
          blockDone, sampleStrobe && blkCnt == spb - 1);
      if (sampleStrobe && blkCnt == 0) begin
        if (mThrEn) chk(freeBytesOf(level) >= mThr, "R2 start space",
                        freeBytesOf(level), mThr);
        else        chk(level < DEPTH, "R5 start space", level, DEPTH - 1);
      end
      if (mThrEn && mThr >= mBlk && blkCnt != 0)
        chk(cardClkEn == 1'b1, "R3 no mid-block stop", cardClkEn, 1);
      if (midStopAllowed(mThrEn, mThr, mBlk) && level >= DEPTH)
        chk(cardClkEn == 1'b0, "R4 full gates", cardClkEn, 0);
      if (!mThrEn && blkCnt != 0)
        chk(cardClkEn == (level < DEPTH), "R5 mid-block", cardClkEn, level < DEPTH);
      if (sampleStrobe && ((byteSmp + 1) % 8 == 0))
        chk(level < DEPTH, "R4 overflow", level + 1, DEPTH);
    end
    if (sampleStrobe) begin
      byteSmp++;
      totSmp++;
      if (byteSmp % 8 == 0) pendPush = 1;
      blkCnt++;
      if (blkCnt == spb) begin
        if (firstDoneAt < 0) firstDoneAt = totSmp;
        blkCnt = 0;
        blocks++;
      end
    end
    if (level > 0 && $urandom_range(99) < drainPct) pendDrain = 1;
  endtask

  task automatic wr(input int addr, input int data);
    pendWr = 1;
    pendAddr = addr;
    pendData = data;
    cycle();
  endtask

  task automatic startXfer(input bit en, input int thr, input int blk);
    mThrEn = en;
    mThr = thr;
    mBlk = blk;
    spb = blk * 2;
    blkCnt = 0;
    blocks = 0;
    byteSmp = 0;
    pendCmd = 1;
    inXfer = 1;
    cycle();
  endtask

  task automatic endXfer();
    pendDone = 1;
    cycle();
    inXfer = 0;
    for (int i = 0; i < 4; i++) begin
      cycle();
      chk(cardClkEn == 1'b0, "R10 idle after done", cardClkEn, 0);
    end
  endtask

  task automatic runXfer(input int nBlk, input bit en, input int thr,
                         input int blk, input int dPct, input int tPct);
    wr(0, en);
    wr(1, thr);
    wr(2, blk);
    drainPct = dPct;
    tickPct = tPct;
    startXfer(en, thr, blk);
    while (blocks < nBlk) cycle();
    endXfer();
  endtask

  task automatic emptyFifo();
    drainPct = 100;
    while (level > 0 || pendPush != 0) cycle();
    cycle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5D1A));
    tickPct = 100;
    // R1: reset
    for (int i = 0; i < 3; i++) begin
      cycle();
      chk({cardClkEn, sampleStrobe, blockDone, stalled} == 4'b0, "R1 in reset",
          {cardClkEn, sampleStrobe, blockDone, stalled}, 0);
    end
    rstN = 1'b1;
    cycle();
    chk({cardClkEn, sampleStrobe, blockDone, stalled} == 4'b0, "R1 after reset",
        {cardClkEn, sampleStrobe, blockDone, stalled}, 0);

    // R11: default block size, threshold off
    drainPct = 60;
    tickPct = 70;
    totSmp = 0;
    firstDoneAt = -1;
    startXfer(0, 0, 512);
    while (blocks < 1) cycle();
    endXfer();
    chk(firstDoneAt == 1024, "R11 default block", firstDoneAt, 1024);
    emptyFifo();

    // R3 / R2: threshold at or above block size
    for (int n = 0; n < 8; n++) begin
      int blk = 4 * $urandom_range(2, 16);
      int thr = blk + 4 * $urandom_range(0, (128 - blk) / 4);
      runXfer($urandom_range(2, 4), 1, thr, blk,
              $urandom_range(10, 70), $urandom_range(30, 100));
    end
    // R2 directed corner: threshold equals the whole FIFO
    runXfer(3, 1, 128, 128, 80, 100);
    emptyFifo();

    // R4: threshold below block size
    for (int n = 0; n < 6; n++) begin
      int blk = 4 * $urandom_range(4, 24);
      int thr = 4 * $urandom_range(1, blk / 4 - 1);
      runXfer($urandom_range(2, 3), 1, thr, blk,
              $urandom_range(5, 40), $urandom_range(50, 100));
    end
    emptyFifo();

    // R5: threshold disabled
    for (int n = 0; n < 6; n++) begin
      int blk = 4 * $urandom_range(2, 50);
      runXfer($urandom_range(1, 3), 0, 0, blk,
              $urandom_range(5, 40), $urandom_range(50, 100));
    end
    emptyFifo();

    // R7 / R8 / R9 directed
    wr(3, 20);
    wr(0, 1);
    wr(1, 128);
    wr(2, 32);
    drainPct = 0;
    tickPct = 100;
    startXfer(1, 128, 32);
    for (int i = 0; i < 12; i++) cycle();
    wr(1, 4);            // R7: ignored while active
    pendCmd = 1;         // R8: ignored while active
    cycle();
    while (blocks < 1) cycle();
    chk(level + pendPush == 8, "R8 one block of words", level + pendPush, 8);
    endXfer();

    startXfer(1, 128, 32);   // FIFO holds 8 words, 96 bytes free
    for (int i = 1; i <= 30; i++) begin
      cycle();
      if (i == 10) chk(stalled == 1'b0, "R9 not yet stalled", stalled, 0);
      if (i == 30) chk(stalled == 1'b1, "R9 stalled", stalled, 1);
    end
    chk(cardClkEn == 1'b0, "R7 old threshold kept", cardClkEn, 0);
    drainPct = 100;
    cycle();
    cycle();
    cycle();
    chk(stalled == 1'b0, "R9 cleared by drain", stalled, 0);
    while (blocks < 1) cycle();
    endXfer();

    // R9: limit 0 disables
    wr(3, 0);
    drainPct = 0;
    wr(2, 16);
    wr(1, 16);
    startXfer(1, 16, 16);
    while (blocks < 1) cycle();
    endXfer();
    level = level;  // FIFO keeps 4 words
    wr(1, 128);
    startXfer(1, 128, 16);
    for (int i = 0; i < 40; i++) cycle();
    chk(stalled == 1'b0, "R9 limit zero", stalled, 0);
    drainPct = 100;
    while (blocks < 1) cycle();
    endXfer();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule